// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit forms the data memory address for every load and store of a 32-bit core whose instructions are 16 bits wide. Each cycle with a valid request it takes an addressing mode, an operand size, the base register value, R0, the global base register (GBR), the program counter and the raw displacement field. It returns the effective address, the updated base value for the two auto-modify modes with a write enable, and a misalignment error flag. All results are registered, so they appear one clock after the request and stay put until the next request.

Displacements are scaled by the operand size in bytes before they are added. The short register-relative field is 4 bits and the GBR and PC fields are 8 bits, all zero-extended. The PC-relative mode adds 4 to the program counter and, for longword operands, first clears the two low PC bits. An address that is not a multiple of the operand size is flagged as an error and its base update is held back. The unit performs no memory access, decodes no opcode and holds no register file.

Top module: `ea_gen`

## Requirements
- R1: A request with in_valid high produces out_valid high on the next clock edge only; the other outputs change only after a request and otherwise hold their last values.
- R2: Mode code 0 (register indirect) gives out_ea = in_base.
- R3: Mode code 1 (post-increment) gives out_ea = in_base and out_wb_val = in_base + operand bytes, where size code 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes (code 3 acts as 4 bytes).
- R4: Mode code 2 (pre-decrement) gives out_ea = out_wb_val = in_base - operand bytes.
- R5: Mode code 3 (register plus displacement) gives out_ea = in_base + in_disp[3:0] * operand bytes; in_disp[7:4] has no effect.
- R6: Mode code 4 gives out_ea = in_base + in_r0, and mode code 6 gives out_ea = in_gbr + in_r0.
- R7: Mode code 5 (GBR plus displacement) gives out_ea = in_gbr + in_disp[7:0] * operand bytes.
- R8: Mode code 7 (PC relative) gives out_ea = P + 4 + in_disp[7:0] * operand bytes, where P is in_pc with bits 1:0 cleared for 4-byte operands and in_pc unchanged otherwise.
- R9: out_misalign is high exactly when out_ea is not a multiple of the operand bytes.
- R10: out_wb_en is high only for mode codes 1 and 2 and only when the access is not misaligned.
- R11: All address and writeback arithmetic wraps modulo 2^32.
- R12: While reset is asserted, out_valid, out_ea, out_wb_en, out_wb_val and out_misalign are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 3 | Addressing mode code |
| in_size | input | 2 | Operand size code |
| in_base | input | 32 | Base register value |
| in_r0 | input | 32 | R0 value |
| in_gbr | input | 32 | Global base register value |
| in_pc | input | 32 | Program counter of the instruction |
| in_disp | input | 8 | Raw displacement field |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_ea | output | 32 | Effective address |
| out_wb_en | output | 1 | Base register update enable |
| out_wb_val | output | 32 | New base register value |
| out_misalign | output | 1 | Misaligned access error |

## Verification
The properties assume that request fields are meaningful only in a cycle where in_valid is high, and that the size code is one of the three defined values; they compare each result to the request captured in the previous cycle. The stimulus drives only size codes 0 to 2, changes inputs on the falling edge, and covers every mode with aligned and misaligned bases, displacements with upper bits set, and bases at both ends of the address space to exercise wrap-around.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    AM_IND    = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC = 3'd2,
    AM_REGDISP = 3'd3,
    AM_REGR0  = 3'd4,
    AM_GBRDISP = 3'd5,
    AM_GBRR0  = 3'd6,
    AM_PCDISP = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    OS_BYTE = 2'd0,
    OS_WORD = 2'd1,
    OS_LONG = 2'd2,
    OS_RSV  = 2'd3
  } osize_e;

  // log2 of operand bytes; the reserved code behaves as a longword
  function automatic logic [1:0] size_shift(input logic [1:0] sz);
    return (sz == OS_RSV) ? 2'd2 : sz;
  endfunction

endpackage

// File: rtl/ea_disp_scale.sv
module ea_disp_scale #(
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 8,
  parameter int SHORT_W = 4
) (
  input  logic [2:0]        mode,
  input  logic [1:0]        size,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] offset
);
  import ea_pkg::*;

  logic [ADDR_W-1:0] zext;

  always_comb begin
    zext = '0;
    if (mode == AM_REGDISP) begin
      zext[SHORT_W-1:0] = disp[SHORT_W-1:0];
    end else begin
      zext[DISP_W-1:0] = disp;
    end
    offset = zext << size_shift(size);
  end

endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        mode,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] r0,
  input  logic [ADDR_W-1:0] gbr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] wb_val,
  output logic              auto_mod
);
  import ea_pkg::*;

  localparam logic [ADDR_W-1:0] PC_BIAS = ADDR_W'(4);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] pc_base;
  logic [ADDR_W-1:0] opnd_a;
  logic [ADDR_W-1:0] opnd_b;

  always_comb begin
    step    = ADDR_W'(1) << size_shift(size);
    pc_base = pc;
    if (size_shift(size) == 2'd2) begin
      pc_base[1:0] = 2'b00;
    end
    opnd_a   = base;
    opnd_b   = '0;
    auto_mod = 1'b0;
    unique case (mode)
      AM_IND:     begin opnd_a = base; opnd_b = '0; end
      AM_POSTINC: begin opnd_a = base; opnd_b = '0; auto_mod = 1'b1; end
      AM_PREDEC:  begin opnd_a = base; opnd_b = -step; auto_mod = 1'b1; end
      AM_REGDISP: begin opnd_a = base; opnd_b = offset; end
      AM_REGR0:   begin opnd_a = base; opnd_b = r0; end
      AM_GBRDISP: begin opnd_a = gbr;  opnd_b = offset; end
      AM_GBRR0:   begin opnd_a = gbr;  opnd_b = r0; end
      AM_PCDISP:  begin opnd_a = pc_base + PC_BIAS; opnd_b = offset; end
      default:    begin opnd_a = base; opnd_b = '0; end
    endcase
    ea = opnd_a + opnd_b;
    if (mode == AM_POSTINC) begin
      wb_val = base + step;
    end else begin
      wb_val = ea;
    end
  end

endmodule

// File: rtl/ea_align_chk.sv
module ea_align_chk #(
  parameter int ADDR_W = 32,
  parameter int N_SIZES = 3
) (
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] ea,
  output logic              misalign
);
  import ea_pkg::*;

  logic [N_SIZES-1:0] bad_for;

  genvar g;
  generate
    for (g = 0; g < N_SIZES; g++) begin : g_sz
      if (g == 0) begin : g_byte
        assign bad_for[g] = 1'b0;
      end else begin : g_wide
        assign bad_for[g] = |ea[g-1:0];
      end
    end
  endgenerate

  assign misalign = bad_for[size_shift(size)];

endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 8,
  parameter int SHORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_mode,
  input  logic [1:0]        in_size,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_r0,
  input  logic [ADDR_W-1:0] in_gbr,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [DISP_W-1:0] in_disp,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_ea,
  output logic              out_wb_en,
  output logic [ADDR_W-1:0] out_wb_val,
  output logic              out_misalign
);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] ea_d;
  logic [ADDR_W-1:0] wb_d;
  logic              auto_mod;
  logic              bad_d;

  logic              vld_q;
  logic [ADDR_W-1:0] ea_q;
  logic [ADDR_W-1:0] wb_q;
  logic              wben_q;
  logic              bad_q;

  logic              wben_d;
  logic              cap_en;

  ea_disp_scale #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SHORT_W(SHORT_W)) u_scale (
    .mode   (in_mode),
    .size   (in_size),
    .disp   (in_disp),
    .offset (offset)
  );

  ea_sum #(.ADDR_W(ADDR_W)) u_sum (
    .mode     (in_mode),
    .size     (in_size),
    .base     (in_base),
    .r0       (in_r0),
    .gbr      (in_gbr),
    .pc       (in_pc),
    .offset   (offset),
    .ea       (ea_d),
    .wb_val   (wb_d),
    .auto_mod (auto_mod)
  );

  ea_align_chk #(.ADDR_W(ADDR_W)) u_align (
    .size     (in_size),
    .ea       (ea_d),
    .misalign (bad_d)
  );

  always_comb begin
    cap_en = in_valid;
    wben_d = auto_mod & ~bad_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q   <= '0;
      wb_q   <= '0;
      wben_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (cap_en) begin
      ea_q   <= ea_d;
      wb_q   <= wb_d;
      wben_q <= wben_d;
      bad_q  <= bad_d;
    end
  end

  assign out_valid    = vld_q;
  assign out_ea       = ea_q;
  assign out_wb_en    = wben_q;
  assign out_wb_val   = wb_q;
  assign out_misalign = bad_q;

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        in_mode,
  input logic [1:0]        in_size,
  input logic [ADDR_W-1:0] in_base,
  input logic [DISP_W-1:0] in_disp,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_ea,
  input logic              out_wb_en,
  input logic [ADDR_W-1:0] out_wb_val,
  input logic              out_misalign
);

  function automatic logic [ADDR_W-1:0] nbytes(input logic [1:0] s);
    return (s == 2'd0) ? ADDR_W'(1) : (s == 2'd1) ? ADDR_W'(2) : ADDR_W'(4);
  endfunction

  // R1: valid follows the request by one cycle
  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_ea));

  // R3: post-increment address and writeback
  p_postinc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd1) |=>
      (out_ea == $past(in_base)) && (out_wb_val == $past(in_base) + nbytes($past(in_size))));

  // R4: pre-decrement address equals writeback
  p_predec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd2) |=>
      (out_ea == out_wb_val) && (out_ea == $past(in_base) - nbytes($past(in_size))));

  // R8: longword PC-relative result is always longword aligned
  p_pc_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd7 && in_size == 2'd2) |=> (out_ea[1:0] == 2'b00));

  // R9: error flag matches the address low bits
  p_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_misalign == ((out_ea & (nbytes($past(in_size)) - 1)) != '0)));

  // R10: writeback only for aligned auto-modify modes
  p_wb_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_wb_en |-> !out_misalign);
  p_wb_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode != 3'd1 && in_mode != 3'd2) |=> !out_wb_en);

endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_mode      (in_mode),
  .in_size      (in_size),
  .in_base      (in_base),
  .in_disp      (in_disp),
  .out_valid    (out_valid),
  .out_ea       (out_ea),
  .out_wb_en    (out_wb_en),
  .out_wb_val   (out_wb_val),
  .out_misalign (out_misalign)
);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_mode;
  logic [1:0]  in_size;
  logic [31:0] in_base, in_r0, in_gbr, in_pc;
  logic [7:0]  in_disp;
  logic        out_valid;
  logic [31:0] out_ea;
  logic        out_wb_en;
  logic [31:0] out_wb_val;
  logic        out_misalign;

  typedef struct {
    logic [31:0] ea;
    logic        wb_en;
    logic [31:0] wb_val;
    logic        bad;
    string       tag;
  } exp_t;

  exp_t exq[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] last_ea;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_size(in_size), .in_base(in_base), .in_r0(in_r0), .in_gbr(in_gbr),
    .in_pc(in_pc), .in_disp(in_disp), .out_valid(out_valid), .out_ea(out_ea),
    .out_wb_en(out_wb_en), .out_wb_val(out_wb_val), .out_misalign(out_misalign)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [31:0] bytes_of(input logic [1:0] s);
    if (s == 2'd0) return 32'd1;
    if (s == 2'd1) return 32'd2;
    return 32'd4;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [1:0] s, input logic [31:0] b,
                       input logic [31:0] r0, input logic [31:0] g, input logic [31:0] p,
                       input logic [7:0] d, input string tag);
    exp_t e;
    logic [31:0] n;
    logic [31:0] pp;
    n = bytes_of(s);
    e.wb_val = 32'h0;
    case (m)
      3'd0: e.ea = b;
      3'd1: begin e.ea = b; e.wb_val = b + n; end
      3'd2: begin e.ea = b - n; e.wb_val = b - n; end
      3'd3: e.ea = b + {28'h0, d[3:0]} * n;
      3'd4: e.ea = b + r0;
      3'd5: e.ea = g + {24'h0, d} * n;
      3'd6: e.ea = g + r0;
      default: begin
        pp = (n == 32'd4) ? {p[31:2], 2'b00} : p;
        e.ea = pp + 32'd4 + {24'h0, d} * n;
      end
    endcase
    e.bad   = (e.ea % n) != 0;
    e.wb_en = (m == 3'd1 || m == 3'd2) && !e.bad;
    e.tag   = tag;
    @(negedge clk);
    in_valid = 1; in_mode = m; in_size = s; in_base = b;
    in_r0 = r0; in_gbr = g; in_pc = p; in_disp = d;
    exq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
    in_base = 32'hDEADBEEF; in_mode = 3'd0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exq.size() == 0) begin
        check(0, "R1", "out_valid with no request pending");
      end else begin
        exp_t e;
        bit ok;
        e = exq.pop_front();
        ok = (out_ea == e.ea) && (out_wb_en == e.wb_en) && (out_misalign == e.bad) &&
             (!e.wb_en || out_wb_val == e.wb_val);
        check(ok, e.tag, $sformatf("ea=%h wb_en=%0b wb=%h err=%0b expected ea=%h wb_en=%0b wb=%h err=%0b",
              out_ea, out_wb_en, out_wb_val, out_misalign, e.ea, e.wb_en, e.wb_val, e.bad));
        last_ea = e.ea;
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_mode = 0; in_size = 0; in_base = 0;
    in_r0 = 0; in_gbr = 0; in_pc = 0; in_disp = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(out_valid == 0 && out_ea == 0 && out_wb_en == 0 && out_wb_val == 0 && out_misalign == 0,
          "R12", $sformatf("valid=%0b ea=%h wb_en=%0b wb=%h err=%0b expected all zero",
          out_valid, out_ea, out_wb_en, out_wb_val, out_misalign));
    rst_n = 1;
    @(negedge clk);

    drive(3'd0, 2'd2, 32'h0000_1000, 0, 0, 0, 8'h00, "R2");
    drive(3'd1, 2'd0, 32'h0000_2001, 0, 0, 0, 8'h00, "R3");
    drive(3'd1, 2'd2, 32'h0000_3000, 0, 0, 0, 8'h00, "R3");
    drive(3'd2, 2'd1, 32'h0000_4000, 0, 0, 0, 8'h00, "R4");
    drive(3'd2, 2'd0, 32'h0000_4001, 0, 0, 0, 8'h00, "R4");
    drive(3'd3, 2'd2, 32'h0000_0100, 0, 0, 0, 8'hF5, "R5");
    drive(3'd3, 2'd1, 32'h0000_0100, 0, 0, 0, 8'h0F, "R5");
    drive(3'd3, 2'd0, 32'h0000_0100, 0, 0, 0, 8'hA3, "R5");
    drive(3'd4, 2'd0, 32'h0000_0010, 32'h20, 0, 0, 8'h00, "R6");
    drive(3'd6, 2'd2, 32'h0000_0000, 32'h4, 32'h8000, 0, 8'h00, "R6");
    drive(3'd5, 2'd1, 32'h0, 0, 32'h100, 0, 8'hFF, "R7");
    drive(3'd5, 2'd2, 32'h0, 0, 32'h200, 0, 8'h80, "R7");
    drive(3'd7, 2'd2, 32'h0, 0, 0, 32'h1002, 8'h03, "R8");
    drive(3'd7, 2'd1, 32'h0, 0, 0, 32'h1002, 8'h01, "R8");
    drive(3'd7, 2'd0, 32'h0, 0, 0, 32'h1001, 8'h00, "R8");
    drive(3'd0, 2'd2, 32'h0000_1002, 0, 0, 0, 8'h00, "R9");
    drive(3'd7, 2'd1, 32'h0, 0, 0, 32'h1003, 8'h02, "R9");
    drive(3'd1, 2'd1, 32'h0000_5001, 0, 0, 0, 8'h00, "R10");
    drive(3'd2, 2'd2, 32'h0000_6002, 0, 0, 0, 8'h00, "R10");
    drive(3'd4, 2'd2, 32'h0000_0010, 32'h10, 0, 0, 8'h00, "R10");
    drive(3'd2, 2'd2, 32'h0000_0000, 0, 0, 0, 8'h00, "R11");
    drive(3'd1, 2'd2, 32'hFFFF_FFFC, 0, 0, 0, 8'h00, "R11");
    drive(3'd5, 2'd0, 32'h0, 0, 32'hFFFF_FFF0, 0, 8'h20, "R11");
    drive(3'd0, 2'd0, 32'h0000_00AB, 0, 0, 0, 8'h00, "R1");
    idle();
    repeat (3) @(negedge clk);
    // R1: outputs hold with no request
    check(out_valid == 0 && out_ea == last_ea && exq.size() == 0, "R1",
          $sformatf("valid=%0b ea=%h pending=%0d expected valid=0 ea=%h pending=0",
          out_valid, out_ea, exq.size(), last_ea));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule